// File: doc/BRIEF.md
# Hit-Event Memory with Serial Readout

This block captures one hit event per bunch crossing from a pixel matrix of three rows by sixteen columns. It stores each event that carries data as one 72-bit word in an event memory, then shifts the stored words out on a single serial pin once acquisition has ended. Acquisition runs while `shutter_i` is high. Each clock cycle with the shutter high is one bunch crossing, and a 16-bit crossing counter tags every stored word.

A 2-bit mode input selects the word format. The raw mode passes the 48 hit bits through unchanged. The centroid mode encodes clusters of adjacent hits as centres. The stub mode packs up to four stubs supplied from outside the block. The memory is cleared when acquisition begins and it never overwrites a stored word: once it is full, further events are dropped. With the shutter low, each falling edge of the readout clock `rd_clk_i` advances the serial output by one bit. The readout clock is sampled on `clk_i`.

Top module: `hit_event_mem`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0 and `ser_o`=0. `empty_o` goes low in the cycle that follows the clock edge storing the first word of an acquisition.
- R2: Mode 2'b11 (raw) stores an event when any hit bit is set. The word is {hits[47:0], bx[15:0], 8'hFF}. Hit bit r*16+p is row r, column p.
- R3: Mode 2'b10 (centroid) treats each maximal run of set hits within a row as one cluster. A cluster gives a 7-bit slot {row[1:0], first+last column[4:0]}. Slot k sits at word bits [71-7k -: 7]. Slots are ordered by row, then by column, and bx fills bits [15:0].
- R4: In centroid mode, slots with no cluster are zero and clusters beyond the eighth are dropped. An event with only such clusters is still stored.
- R5: Mode 2'b00 (stub) compacts the valid stubs in slot order. Stub input k is `stubs_i[13k +: 13]` and is valid when `stub_vld_i[k]` is set. Stored slot j sits at bits [71-13j -: 13]. Unused slots are zero, followed by bx[15:0] at bits [19:4] and 4'hF.
- R6: An event with no data is not stored. Mode 2'b01 never stores. No word is stored while the shutter is low.
- R7: bx is 0 in the first shutter-high cycle and increments by 1 each cycle after that, wrapping from 65535 to 0.
- R8: After DEPTH words, `full_o`=1 and further events are discarded. The stored words remain unchanged.
- R9: A rising edge of the shutter empties the memory, so `empty_o`=1 and `full_o`=0 when that crossing has no data.
- R10: While the shutter is low, each falling edge of `rd_clk_i` advances `ser_o` by one bit. Bits go out from bit 71 down to bit 0, and words from the first stored to the last. While the shutter is high, the readout position is held at bit 71 of the first word.
- R11: Once the readout position is past the last stored word, `ser_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; one bunch crossing per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutter_i | input | 1 | High: acquire; low: read out |
| mode_i | input | 2 | Word format select |
| hits_i | input | 48 | Hit bits of the current crossing |
| stubs_i | input | 52 | Four 13-bit stubs {row, bend, position} |
| stub_vld_i | input | 4 | Per-stub valid |
| rd_clk_i | input | 1 | Readout clock, shifts on its falling edge |
| ser_o | output | 1 | Serial readout data |
| full_o | output | 1 | Memory holds DEPTH words |
| empty_o | output | 1 | Memory holds no word |

## Verification
The bench builds the block with DEPTH=4, so that the full condition and the discard of extra events are reached within a few crossings. It can then check that a fifth and a sixth event leave the four stored words intact and that reading past them gives zeros. The crossing counter keeps its full 16-bit width. A single long acquisition therefore runs past 65535 and confirms the wrap of the tag stored with the words.

// File: rtl/hem_pkg.sv
`timescale 1ns/1ps
package hem_pkg;
  localparam int ROWS      = 3;
  localparam int COLS      = 16;
  localparam int NPIX      = ROWS * COLS;
  localparam int BX_W      = 16;
  localparam int WORD_W    = 72;
  localparam int ROW_W     = 2;
  localparam int CPOS_W    = 5;
  localparam int CENT_W    = ROW_W + CPOS_W;
  localparam int NCENT     = 8;
  localparam int BEND_W    = 5;
  localparam int SPOS_W    = 6;
  localparam int STUB_W    = ROW_W + BEND_W + SPOS_W;
  localparam int NSTUB     = 4;
  localparam int RAW_TAIL  = WORD_W - NPIX - BX_W;
  localparam int STUB_TAIL = WORD_W - NSTUB * STUB_W - BX_W;
  localparam int BIT_W     = $clog2(WORD_W);

  typedef enum logic [1:0] {
    M_STUB  = 2'b00,
    M_STRIP = 2'b01,
    M_CENT  = 2'b10,
    M_RAW   = 2'b11
  } mode_e;
endpackage

// File: rtl/hem_bx_ctr.sv
`timescale 1ns/1ps
module hem_bx_ctr
  import hem_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shutter_i,
  output logic            start_o,
  output logic [BX_W-1:0] bx_o
);
  logic            shut_q;
  logic [BX_W-1:0] bx_q;

  assign start_o = shutter_i & ~shut_q;
  assign bx_o    = start_o ? '0 : bx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shut_q <= 1'b0;
      bx_q   <= '0;
    end else begin
      shut_q <= shutter_i;
      if (shutter_i) bx_q <= bx_o + 1'b1;
    end
  end
endmodule

// File: rtl/hem_fmt.sv
`timescale 1ns/1ps
module hem_fmt
  import hem_pkg::*;
(
  input  logic [1:0]            mode_i,
  input  logic [NPIX-1:0]       hits_i,
  input  logic [NSTUB*STUB_W-1:0] stubs_i,
  input  logic [NSTUB-1:0]      stub_vld_i,
  input  logic [BX_W-1:0]       bx_i,
  output logic [WORD_W-1:0]     word_o,
  output logic                  has_o
);
  logic [COLS+1:0] pad;

  always_comb begin
    int n;
    int st;
    n      = 0;
    st     = 0;
    pad    = '0;
    word_o = '0;
    has_o  = 1'b0;
    case (mode_i)
      M_RAW: begin
        has_o  = |hits_i;
        word_o = {hits_i, bx_i, {RAW_TAIL{1'b1}}};
      end
      M_CENT: begin
        for (int r = 0; r < ROWS; r++) begin
          pad = {1'b0, hits_i[r*COLS +: COLS], 1'b0};
          st  = 0;
          for (int p = 0; p < COLS; p++) begin
            if (pad[p+1] && !pad[p]) st = p;
            // run ends at p: emit centre in half-pixel units
            if (pad[p+1] && !pad[p+2]) begin
              has_o = 1'b1;
              if (n < NCENT) begin
                word_o[WORD_W-1-n*CENT_W -: CENT_W] = {ROW_W'(r), CPOS_W'(st + p)};
                n++;
              end
            end
          end
        end
        word_o[BX_W-1:0] = bx_i;
      end
      M_STUB: begin
        for (int k = 0; k < NSTUB; k++) begin
          if (stub_vld_i[k]) begin
            has_o = 1'b1;
            word_o[WORD_W-1-n*STUB_W -: STUB_W] = stubs_i[k*STUB_W +: STUB_W];
            n++;
          end
        end
        word_o[STUB_TAIL +: BX_W]  = bx_i;
        word_o[STUB_TAIL-1:0]      = '1;
      end
      default: begin
        has_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hem_store.sv
`timescale 1ns/1ps
module hem_store
  import hem_pkg::*;
#(
  parameter int DEPTH  = 96,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shutter_i,
  input  logic              start_i,
  input  logic              has_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] waddr;
  logic              room;
  logic              we;

  assign room    = start_i || (cnt_q < CNT_W'(DEPTH));
  assign we      = shutter_i && has_i && room;
  assign waddr   = start_i ? '0 : cnt_q[ADDR_W-1:0];
  assign rdata_o = mem[raddr_i];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (we) mem[waddr] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(has_i);
    else if (we)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hem_serout.sv
`timescale 1ns/1ps
module hem_serout
  import hem_pkg::*;
#(
  parameter int DEPTH  = 96,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shutter_i,
  input  logic              rd_clk_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [CNT_W-1:0]  rd_word_o,
  output logic [BIT_W-1:0]  rd_bit_o,
  output logic              ser_o
);
  logic             rd_q;
  logic             fall;
  logic [CNT_W-1:0] word_q;
  logic [BIT_W-1:0] bit_q;

  assign fall      = rd_q & ~rd_clk_i;
  assign raddr_o   = word_q[ADDR_W-1:0];
  assign ser_o     = (word_q < cnt_i) ? rdata_i[bit_q] : 1'b0;
  assign rd_word_o = word_q;
  assign rd_bit_o  = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      word_q <= '0;
      bit_q  <= BIT_W'(WORD_W - 1);
    end else begin
      rd_q <= rd_clk_i;
      if (shutter_i) begin
        word_q <= '0;
        bit_q  <= BIT_W'(WORD_W - 1);
      end else if (fall) begin
        if (bit_q == '0) begin
          bit_q <= BIT_W'(WORD_W - 1);
          if (word_q != CNT_W'(DEPTH)) word_q <= word_q + 1'b1;
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hit_event_mem.sv
`timescale 1ns/1ps
module hit_event_mem
  import hem_pkg::*;
#(
  parameter int DEPTH  = 96,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shutter_i,
  input  logic [1:0]              mode_i,
  input  logic [NPIX-1:0]         hits_i,
  input  logic [NSTUB*STUB_W-1:0] stubs_i,
  input  logic [NSTUB-1:0]        stub_vld_i,
  input  logic                    rd_clk_i,
  output logic                    ser_o,
  output logic                    full_o,
  output logic                    empty_o
);
  logic              start;
  logic [BX_W-1:0]   bx;
  logic [WORD_W-1:0] word;
  logic              has;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;
  logic [CNT_W-1:0]  wr_cnt;
  logic [CNT_W-1:0]  rd_word;
  logic [BIT_W-1:0]  rd_bit;

  hem_bx_ctr u_bx (
    .clk_i, .rst_ni, .shutter_i,
    .start_o (start),
    .bx_o    (bx)
  );

  hem_fmt u_fmt (
    .mode_i, .hits_i, .stubs_i, .stub_vld_i,
    .bx_i   (bx),
    .word_o (word),
    .has_o  (has)
  );

  hem_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .shutter_i,
    .start_i (start),
    .has_i   (has),
    .word_i  (word),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .cnt_o   (wr_cnt)
  );

  hem_serout #(.DEPTH(DEPTH)) u_ser (
    .clk_i, .rst_ni, .shutter_i, .rd_clk_i,
    .cnt_i     (wr_cnt),
    .rdata_i   (rdata),
    .raddr_o   (raddr),
    .rd_word_o (rd_word),
    .rd_bit_o  (rd_bit),
    .ser_o
  );

  assign full_o  = (wr_cnt == CNT_W'(DEPTH));
  assign empty_o = (wr_cnt == '0);
endmodule

// File: rtl/hit_event_mem_chk.sv
`timescale 1ns/1ps
module hit_event_mem_chk
  import hem_pkg::*;
#(
  parameter int DEPTH  = 96,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shutter_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             start,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [CNT_W-1:0] rd_word,
  input logic [BIT_W-1:0] rd_bit
);
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt <= CNT_W'(DEPTH));

  a_r8_full_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && shutter_i && !start) |=> $stable(wr_cnt));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (wr_cnt <= CNT_W'(1)));

  a_r1_empty_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(shutter_i));

  a_r6_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutter_i |=> $stable(wr_cnt));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutter_i |=> (rd_word == '0 && rd_bit == BIT_W'(WORD_W - 1)));
endmodule

bind hit_event_mem hit_event_mem_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shutter_i (shutter_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .start     (start),
  .wr_cnt    (wr_cnt),
  .rd_word   (rd_word),
  .rd_bit    (rd_bit)
);

// File: tb/sim_hit_event_mem.sv
`timescale 1ns/1ps
module sim_hit_event_mem;
  localparam int DEPTH = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic [47:0] hits;
    logic [51:0] stubs;
    logic [3:0]  vld;
    logic [71:0] exp;
    logic        exp_empty;
  } vec_t;

  localparam vec_t VEC [7] = '{
    // R2 raw, corner bits
    '{2'b11, 48'h800000000001, 52'h0, 4'h0, {48'h800000000001, 16'h0000, 8'hFF}, 1'b0},
    // R2 raw, mixed pattern
    '{2'b11, 48'h123456789ABC, 52'h0, 4'h0, {48'h123456789ABC, 16'h0000, 8'hFF}, 1'b0},
    // R3 two clusters: row0 cols 3..5, row2 col 15
    '{2'b10, 48'h800000000038, 52'h0, 4'h0, {7'h08, 7'h5E, 42'h0, 16'h0000}, 1'b0},
    // R4 nine clusters, ninth dropped
    '{2'b10, 48'h000000015555, 52'h0, 4'h0,
      {7'd0, 7'd4, 7'd8, 7'd12, 7'd16, 7'd20, 7'd24, 7'd28, 16'h0000}, 1'b0},
    // R5 stubs 0 and 2 valid, 1 invalid
    '{2'b00, 48'h0, {13'h0000, 13'h1234, 13'h1FFF, 13'h0ABC}, 4'b0101,
      {13'h0ABC, 13'h1234, 26'h0, 16'h0000, 4'hF}, 1'b0},
    // R6 mode 01 never stores
    '{2'b01, 48'hFFFFFFFFFFFF, 52'h0, 4'hF, 72'h0, 1'b1},
    // R6 raw with no hits
    '{2'b11, 48'h0, 52'h0, 4'h0, 72'h0, 1'b1}
  };

  string vtag [7] = '{"R2", "R2", "R3", "R4", "R5", "R6", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shutter = 1'b0;
  logic        rd_clk = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic [47:0] hits = '0;
  logic [51:0] stubs = '0;
  logic [3:0]  vld = '0;
  logic        ser, full, empty;
  logic [71:0] w;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  hit_event_mem #(.DEPTH(DEPTH)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .shutter_i (shutter), .mode_i (mode),
    .hits_i (hits), .stubs_i (stubs), .stub_vld_i (vld), .rd_clk_i (rd_clk),
    .ser_o (ser), .full_o (full), .empty_o (empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_word(output logic [71:0] r);
    for (int b = 71; b >= 0; b--) begin
      r[b] = ser;
      rd_clk = 1'b1;
      @(negedge clk);
      rd_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 180000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(empty == 1'b1, "R1", 72'(empty), 72'd1);
    chk(full == 1'b0, "R1", 72'(full), 72'd0);
    chk(ser == 1'b0, "R1", 72'(ser), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      mode = VEC[i].mode; hits = VEC[i].hits; stubs = VEC[i].stubs; vld = VEC[i].vld;
      shutter = 1'b1;
      @(negedge clk);
      hits = '0; vld = '0;
      @(negedge clk);
      shutter = 1'b0;
      @(negedge clk);
      chk(empty == VEC[i].exp_empty, vtag[i], 72'(empty), 72'(VEC[i].exp_empty));
      read_word(w);
      chk(w == VEC[i].exp, vtag[i], w, VEC[i].exp);
      @(negedge clk);
    end

    // R7 R10 R1: tags and order across words
    mode = 2'b11;
    chk(empty == 1'b1, "R1", 72'(empty), 72'd1);
    shutter = 1'b1; hits = 48'hA;
    @(negedge clk);
    chk(empty == 1'b0, "R1", 72'(empty), 72'd0);
    hits = '0;
    @(negedge clk); hits = 48'hB;
    @(negedge clk); hits = '0;
    @(negedge clk);
    @(negedge clk); hits = 48'hC;
    @(negedge clk); hits = '0; shutter = 1'b0;
    @(negedge clk);
    read_word(w); chk(w == {48'hA, 16'd0, 8'hFF}, "R10", w, {48'hA, 16'd0, 8'hFF});
    read_word(w); chk(w == {48'hB, 16'd2, 8'hFF}, "R7", w, {48'hB, 16'd2, 8'hFF});
    read_word(w); chk(w == {48'hC, 16'd5, 8'hFF}, "R7", w, {48'hC, 16'd5, 8'hFF});
    read_word(w); chk(w == 72'h0, "R11", w, 72'h0);

    // R8 full and discard
    shutter = 1'b1;
    for (int i = 0; i < 6; i++) begin
      hits = 48'(i + 1);
      @(negedge clk);
    end
    hits = '0; shutter = 1'b0;
    @(negedge clk);
    chk(full == 1'b1, "R8", 72'(full), 72'd1);
    for (int i = 0; i < DEPTH; i++) begin
      read_word(w);
      chk(w == {48'(i + 1), 16'(i), 8'hFF}, "R8", w, {48'(i + 1), 16'(i), 8'hFF});
    end
    read_word(w); chk(w == 72'h0, "R11", w, 72'h0);

    // R9 clear on reopen
    shutter = 1'b1;
    @(negedge clk);
    shutter = 1'b0;
    @(negedge clk);
    chk(empty == 1'b1, "R9", 72'(empty), 72'd1);
    chk(full == 1'b0, "R9", 72'(full), 72'd0);
    read_word(w); chk(w == 72'h0, "R9", w, 72'h0);

    // R10 readout clock ignored while shutter high
    shutter = 1'b1; hits = 48'h5;
    @(negedge clk);
    hits = '0;
    for (int i = 0; i < 6; i++) begin
      rd_clk = ~rd_clk;
      @(negedge clk);
    end
    rd_clk = 1'b0;
    @(negedge clk);
    shutter = 1'b0;
    @(negedge clk);
    read_word(w); chk(w == {48'h5, 16'd0, 8'hFF}, "R10", w, {48'h5, 16'd0, 8'hFF});

    // R7 wrap of the crossing counter
    shutter = 1'b1; hits = '0;
    repeat (65536) @(negedge clk);
    hits = 48'h1;
    @(negedge clk); hits = 48'h2;
    @(negedge clk); hits = '0; shutter = 1'b0;
    @(negedge clk);
    read_word(w); chk(w == {48'h1, 16'd0, 8'hFF}, "R7", w, {48'h1, 16'd0, 8'hFF});
    read_word(w); chk(w == {48'h2, 16'd1, 8'hFF}, "R7", w, {48'h2, 16'd1, 8'hFF});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule